// File: doc/BRIEF.md
# Dual-Port Sequential Access Memory

This block is a word store for streaming data. It has one write port and one read port, and neither port takes an address. Each port picks its word with a single set bit that circulates through a shift register. That bit moves to the next word after every accepted access on its port, and it wraps from the last word back to word 0. A writer and a reader can work in the same cycle, so words leave in the order they arrived. The read position trails the write position by however many words are currently stored, so the block is not a fixed-delay line.

A separate occupancy counter guards the two ports. When the store is full it holds off the writer, and when the store is empty it holds off the reader. The counter never feeds word selection. Both ports use a valid/ready handshake. Read data is registered and comes with its own qualifier one cycle after the read is accepted. Two flags, full and empty, report the occupancy limits.

Top module: `sam_dual_port`

## Requirements
- R1: After reset, `wr_ready`=1, `rd_valid`=0, `empty`=1, `full`=0 and `rd_data_vld`=0.
- R2: Each port's selection register holds exactly one set bit at all times. Both start at word 0 and wrap from word DEPTH-1 back to word 0.
- R3: A write is accepted in a cycle where `wr_valid` and `wr_ready` are both 1. The word is stored at the write token's position, and the token moves one word onward. The token does not move in any other cycle.
- R4: A read is accepted in a cycle where `rd_valid` and `rd_ready` are both 1. In the next cycle `rd_data` carries the word at the read token's position and `rd_data_vld`=1, and the read token moves one word onward. Otherwise `rd_data_vld`=0 and `rd_data` keeps its previous value.
- R5: When DEPTH words are stored, `full`=1 and `wr_ready`=0. A write offered in that state is ignored, and the stored words read back unchanged.
- R6: When no word is stored, `empty`=1 and `rd_valid`=0. A read requested in that state is ignored, and `rd_data_vld` stays 0.
- R7: When a write and a read are both accepted in one cycle, occupancy does not change and both tokens advance.
- R8: On an empty store, a write and a read offered in the same cycle store the word but refuse the read. The incoming word is not forwarded. It is offered through `rd_valid` from the next cycle on.
- R9: On a full store, a write and a read offered in the same cycle accept only the read. The write is refused because `wr_ready`=0.
- R10: Continuous streaming over many wraps of both tokens delivers every word exactly once, in the order it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Writer offers a word |
| wr_ready | output | 1 | Store can take a word (not full) |
| wr_data | input | WIDTH | Word offered for writing |
| rd_ready | input | 1 | Reader asks for a word |
| rd_valid | output | 1 | A stored word is available (not empty) |
| rd_data | output | WIDTH | Registered read word |
| rd_data_vld | output | 1 | `rd_data` carries the word of the read accepted in the previous cycle |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No word stored |

## Verification
The handshake outputs `wr_ready`, `rd_valid`, `full` and `empty` depend only on registered occupancy. The bench therefore samples them on the falling edge after it drives a cycle's inputs, and decides acceptance from those values. Write acceptance, token movement and the occupancy change all take effect at the next rising edge. The read word and `rd_data_vld` appear one edge after acceptance, so each cycle task waits exactly one falling edge before it compares them against a queue model. In cycles with no accepted read, the same comparison checks that `rd_data` holds its previous value and that the qualifier stays low.

// File: rtl/sam_pkg.sv
package sam_pkg;

    // Access kind seen by the occupancy counter, encoded as {write, read}.
    typedef enum logic [1:0] {
        ACC_IDLE = 2'b00,
        ACC_RD   = 2'b01,
        ACC_WR   = 2'b10,
        ACC_BOTH = 2'b11
    } sam_acc_e;

endpackage

// File: rtl/sam_token_ring.sv
module sam_token_ring #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [DEPTH-1:0] tok
);
    typedef struct packed {
        logic [DEPTH-1:0] tok;
    } ring_t;

    ring_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.tok = {st_q.tok[DEPTH-2:0], st_q.tok[DEPTH-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tok <= {{(DEPTH-1){1'b0}}, 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign tok = st_q.tok;
endmodule

// File: rtl/sam_occupancy.sv
module sam_occupancy #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fire,
    input  logic rd_fire,
    output logic full,
    output logic empty
);
    import sam_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          full;
        logic          empty;
    } occ_t;

    occ_t     st_d, st_q;
    sam_acc_e kind;

    always_comb begin
        kind = sam_acc_e'({wr_fire, rd_fire});
        st_d = st_q;
        case (kind)
            ACC_WR:  st_d.cnt = st_q.cnt + CW'(1);
            ACC_RD:  st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.full  = (st_d.cnt == CW'(DEPTH));
        st_d.empty = (st_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.full  <= 1'b0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign full  = st_q.full;
    assign empty = st_q.empty;
endmodule

// File: rtl/sam_word_array.sv
module sam_word_array #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DEPTH-1:0] wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [DEPTH-1:0] rd_sel,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_data_vld
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             vld;
    } rd_t;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] gather;
    rd_t              st_d, st_q;

    // One write strobe per word, taken directly from the token bit.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && wr_sel[i]) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    // Read mux as an AND-OR tree driven by the one-hot token.
    always_comb begin
        gather = '0;
        for (int i = 0; i < DEPTH; i++) begin
            gather = gather | (mem_q[i] & {WIDTH{rd_sel[i]}});
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_en;
        if (rd_en) begin
            st_d.data = gather;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = st_q.data;
    assign rd_data_vld = st_q.vld;
endmodule

// File: rtl/sam_dual_port.sv
module sam_dual_port #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_data_vld,
    output logic             full,
    output logic             empty
);
    logic             wr_fire, rd_fire;
    logic [DEPTH-1:0] wr_tok, rd_tok;

    assign wr_ready = !full;
    assign rd_valid = !empty;
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_ready && rd_valid;

    sam_token_ring #(.DEPTH(DEPTH)) u_wr_ring (
        .clk(clk), .rst_n(rst_n), .adv(wr_fire), .tok(wr_tok)
    );

    sam_token_ring #(.DEPTH(DEPTH)) u_rd_ring (
        .clk(clk), .rst_n(rst_n), .adv(rd_fire), .tok(rd_tok)
    );

    sam_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
        .full(full), .empty(empty)
    );

    sam_word_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_fire), .wr_sel(wr_tok), .wr_data(wr_data),
        .rd_en(rd_fire), .rd_sel(rd_tok),
        .rd_data(rd_data), .rd_data_vld(rd_data_vld)
    );
endmodule

// File: rtl/sam_dual_port_chk.sv
module sam_dual_port_chk #(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             rd_ready,
    input logic             rd_valid,
    input logic             rd_data_vld,
    input logic             full,
    input logic             empty,
    input logic [DEPTH-1:0] wr_tok,
    input logic [DEPTH-1:0] rd_tok
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_acc, rd_acc;
    logic [CW-1:0] ref_cnt;

    assign wr_acc = wr_valid && wr_ready;
    assign rd_acc = rd_ready && rd_valid;

    // Independent occupancy count, built from the port handshakes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
        end else begin
            ref_cnt <= ref_cnt + CW'(wr_acc) - CW'(rd_acc);
        end
    end

    assert_tok_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wr_tok) == 1) && ($countones(rd_tok) == 1));

    assert_wr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> wr_tok == {$past(wr_tok[DEPTH-2:0]), $past(wr_tok[DEPTH-1])});

    assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(wr_tok));

    assert_rd_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_tok == {$past(rd_tok[DEPTH-2:0]), $past(rd_tok[DEPTH-1])});

    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_data_vld);

    assert_rd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rd_data_vld);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cnt <= CW'(DEPTH)) && (full == (ref_cnt == CW'(DEPTH))));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (ref_cnt == '0));

    assert_tok_meet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ref_cnt == '0) || (ref_cnt == CW'(DEPTH))) |-> (wr_tok == rd_tok));

    assert_empty_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_valid);

    assert_full_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_ready);
endmodule

bind sam_dual_port sam_dual_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data_vld(rd_data_vld),
    .full(full), .empty(empty), .wr_tok(wr_tok), .rd_tok(rd_tok)
);

// File: tb/tb_sam_dual_port.sv
module tb_sam_dual_port;
    localparam int DEPTH = 4;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_ready = 1'b0;
    logic             rd_valid;
    logic [WIDTH-1:0] rd_data;
    logic             rd_data_vld;
    logic             full;
    logic             empty;

    int               checks = 0;
    int               errors = 0;
    logic [WIDTH-1:0] model [$];
    logic [WIDTH-1:0] last_rd = '0;

    always #5 clk = ~clk;

    sam_dual_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_data_vld(rd_data_vld), .full(full), .empty(empty)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock cycle, entered and left on a falling edge.
    task automatic cyc(input logic wv, input logic [WIDTH-1:0] wd, input logic rr,
                       input string tag);
        logic             exp_wr, exp_rv, wacc, racc;
        logic [WIDTH-1:0] exp_d;
        exp_wr = (model.size() < DEPTH);
        exp_rv = (model.size() > 0);
        wr_valid = wv; wr_data = wd; rd_ready = rr;
        #1;
        chk(wr_ready == exp_wr, {tag, " wr_ready"}, 32'(wr_ready), 32'(exp_wr));
        chk(rd_valid == exp_rv, {tag, " rd_valid"}, 32'(rd_valid), 32'(exp_rv));
        chk(full == !exp_wr, {tag, " full"}, 32'(full), 32'(!exp_wr));
        chk(empty == !exp_rv, {tag, " empty"}, 32'(empty), 32'(!exp_rv));
        wacc = wv && exp_wr;
        racc = rr && exp_rv;
        exp_d = last_rd;
        if (racc) exp_d = model.pop_front();
        if (wacc) model.push_back(wd);
        @(negedge clk);
        wr_valid = 1'b0; rd_ready = 1'b0;
        chk(rd_data_vld == racc, {tag, " R4 rd_data_vld"}, 32'(rd_data_vld), 32'(racc));
        chk(rd_data == exp_d, {tag, " R4 rd_data"}, 32'(rd_data), 32'(exp_d));
        last_rd = exp_d;
    endtask

    task automatic drain(input string tag);
        while (model.size() > 0) cyc(1'b0, '0, 1'b1, tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model.delete();
        last_rd = '0;
        #1;
        chk(wr_ready == 1'b1, "R1 wr_ready", 32'(wr_ready), 1);
        chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
        chk(empty == 1'b1, "R1 empty", 32'(empty), 1);
        chk(full == 1'b0, "R1 full", 32'(full), 0);
        chk(rd_data_vld == 1'b0, "R1 rd_data_vld", 32'(rd_data_vld), 0);
        @(negedge clk);
    endtask

    // Fill, offer a write while full, drain in order, then read while empty.
    task automatic t_fill_drain;
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 16'h1100 + 16'(i), 1'b0, "R3");
        cyc(1'b1, 16'hDEAD, 1'b0, "R5 write while full");
        cyc(1'b0, '0, 1'b0, "R5 idle while full");
        drain("R5 R4 readback");
        cyc(1'b0, '0, 1'b1, "R6 read while empty");
        cyc(1'b0, '0, 1'b1, "R6 second read while empty");
    endtask

    task automatic t_empty_simul;
        cyc(1'b1, 16'hA5A5, 1'b1, "R8 both on empty");
        cyc(1'b0, '0, 1'b0, "R8 word now offered");
        cyc(1'b0, '0, 1'b1, "R8 read after");
    endtask

    task automatic t_full_simul;
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 16'h2200 + 16'(i), 1'b0, "R9 fill");
        cyc(1'b1, 16'hBEEF, 1'b1, "R9 both on full");
        cyc(1'b1, 16'h2299, 1'b0, "R9 refill one");
        drain("R9 drain");
    endtask

    // Streaming with a partly filled store: tokens wrap several times.
    task automatic t_stream;
        cyc(1'b1, 16'h3000, 1'b0, "R10 prime");
        cyc(1'b1, 16'h3001, 1'b0, "R10 prime");
        for (int i = 2; i < 3 * DEPTH + 2; i++)
            cyc(1'b1, 16'h3000 + 16'(i), 1'b1, "R7 R2 R10 stream");
        cyc(1'b0, '0, 1'b0, "R7 level kept");
        drain("R10 drain");
        for (int i = 0; i < 2 * DEPTH; i++)
            cyc(1'b1, 16'h4000 + 16'(i), (i % 3) != 0, "R10 mixed");
        drain("R10 mixed drain");
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_drain();
        t_empty_simul();
        t_full_simul();
        t_stream();
        t_reset();
        t_stream();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule